// File: doc/BRIEF.md
# Per-Channel Serial Output Framer

This block turns one channel's results into a single serial bit stream. It runs on a bit clock that is eight times the bunch-crossing (BC) rate, so an 8-bit frame fills exactly one BC. At each frame boundary it picks one of four sources: the filtered energy byte, a programmable constant, the low byte of a seeded pseudo-random generator, or a raw 10-bit ADC sample. It then shifts the frame out least significant bit first. Raw samples travel as 10-bit frames. All other sources travel as 8-bit frames. A frame-size flag shows which kind of frame is on the line, and a start-of-frame flag marks the bit time that carries the LSB.

The energy and raw-sample inputs are valid/ready streams. The framer raises the ready of the selected stream for exactly one cycle, the cycle whose clock edge loads the next frame. A producer must hold its data and valid until it sees valid and ready high together. If valid is low in that cycle, the frame carries all zeros and nothing is consumed. The constant, seed and delay settings are plain control inputs.

Source and size choices take effect only at a frame boundary, so a frame in progress always completes. All three outputs pass through a programmable delay line. Coarse adjustment adds whole BCs and fine adjustment adds eighths of a BC, which lines the channel up with the rest of the system.

Top module: `serial_framer`

## Requirements
- R1: While reset is asserted, ser_o, sof_o, f10_o, en_ready and raw_ready are all low.
- R2: With src_sel = 00, each frame is 8 bits and carries the energy byte. en_ready is high exactly in the cycle before each frame-load edge. A byte is taken when en_valid and en_ready are both high, and a load without en_valid sends 8'h00.
- R3: With src_sel = 01, each frame is 8 bits and carries the const_val value present at the load edge.
- R4: With src_sel = 10, each frame carries bits [7:0] of a 16-bit generator as they stood just before the load edge. On each shift the generator moves left and takes in the XNOR of its bits 15, 14, 12 and 3 (zero-based). A seed_load pulse copies seed_val in. The all-ones state locks the generator and must not be used as a seed.
- R5: With src_sel = 11, each frame is 10 bits and carries the raw sample, handshaken on raw_valid/raw_ready exactly as in R2 (zero when not valid). f10_o is high for every bit of a 10-bit frame and low for every bit of an 8-bit frame. en_ready and raw_ready are never high together.
- R6: Frames go out LSB first and back to back. sof_o is high only in the bit time that carries a frame's LSB.
- R7: A change of src_sel in the middle of a frame changes neither the content nor the length of that frame. The change takes effect at the next load.
- R8: The port outputs lag the internal frame by 1 + 8*coarse_dly + fine_dly bit clocks, giving a range of 1 to 32.
- R9: When neither seed_load nor lfsr_shift is high, the generator holds its state. seed_load takes priority over lfsr_shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 8x BC |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Source: 00 energy, 01 constant, 10 generator, 11 raw |
| const_val | input | 8 | Constant frame value |
| seed_val | input | 16 | Generator seed |
| seed_load | input | 1 | Load seed into generator |
| lfsr_shift | input | 1 | Shared generator advance enable |
| coarse_dly | input | 2 | Whole-BC delay, 0 to 3 |
| fine_dly | input | 3 | Eighth-BC delay, 0 to 7 |
| en_data | input | 8 | Energy byte |
| en_valid | input | 1 | Energy byte valid |
| en_ready | output | 1 | Energy byte taken on this edge |
| raw_data | input | 10 | Raw ADC sample |
| raw_valid | input | 1 | Raw sample valid |
| raw_ready | output | 1 | Raw sample taken on this edge |
| ser_o | output | 1 | Serial data, LSB first |
| sof_o | output | 1 | LSB of a frame on ser_o |
| f10_o | output | 1 | High during 10-bit frames |

## Verification
The bench switches src_sel at odd offsets inside frames, including switches between 8-bit and 10-bit sources. A framer that latched the source live would truncate a frame or stretch it, and the start-of-frame spacing and frame content would then drift from the model. It withholds valid at some loads, which catches a design that sends stale data instead of zeros or that raises ready at the wrong moment. It runs the extreme delay settings (1 and 32 bit clocks) and a middle one, and an off-by-one tap would show up as every frame arriving a cycle early or late. It also loads seeds and pulses the shift enable around frame loads, so a generator with a wrong tap, or a frame that sampled the generator after it advanced instead of before, yields wrong bytes.

// File: rtl/framer_pkg.sv
package framer_pkg;
  typedef enum logic [1:0] {
    SRC_ENERGY = 2'b00,
    SRC_CONST  = 2'b01,
    SRC_PRBS   = 2'b10,
    SRC_RAW    = 2'b11
  } src_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RAW_W  = 10;
endpackage

// File: rtl/framer_lfsr.sv
module framer_lfsr #(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    TAPS = 16'hD008
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         shift,
  output logic [W-1:0] q
);
  logic fb;
  assign fb = ~(^(q & TAPS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= seed;
    else if (shift) q <= {q[W-2:0], fb};
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(q));
  p_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(seed)));
endmodule

// File: rtl/framer_frame.sv
module framer_frame
  import framer_pkg::*;
#(
  parameter int unsigned SHORT_W = BYTE_W,
  parameter int unsigned LONG_W  = RAW_W,
  parameter int unsigned GEN_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         src_sel,
  input  logic [SHORT_W-1:0] const_val,
  input  logic [GEN_W-1:0]   gen_q,
  input  logic [SHORT_W-1:0] en_data,
  input  logic               en_valid,
  output logic               en_ready,
  input  logic [LONG_W-1:0]  raw_data,
  input  logic               raw_valid,
  output logic               raw_ready,
  output logic               bit_q,
  output logic               sof_q,
  output logic               long_q
);
  localparam int unsigned PW = $clog2(LONG_W);
  localparam logic [PW-1:0] SHORT_LAST = PW'(SHORT_W - 1);
  localparam logic [PW-1:0] LONG_LAST  = PW'(LONG_W - 1);

  logic [LONG_W-1:0] sreg;
  logic [PW-1:0]     pos;
  logic              is_last;
  logic [LONG_W-1:0] next_word;
  logic              next_long;
  src_e              src;

  assign src     = src_e'(src_sel);
  assign is_last = (pos == (long_q ? LONG_LAST : SHORT_LAST));

  always_comb begin
    next_word = '0;
    next_long = 1'b0;
    unique case (src)
      SRC_ENERGY: if (en_valid) next_word = LONG_W'(en_data);
      SRC_CONST:  next_word = LONG_W'(const_val);
      SRC_PRBS:   next_word = LONG_W'(gen_q[SHORT_W-1:0]);
      SRC_RAW: begin
        next_long = 1'b1;
        if (raw_valid) next_word = raw_data;
      end
      default: next_word = '0;
    endcase
  end

  assign en_ready  = rst_n && is_last && (src == SRC_ENERGY);
  assign raw_ready = rst_n && is_last && (src == SRC_RAW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      pos    <= SHORT_LAST;
      long_q <= 1'b0;
    end else if (is_last) begin
      sreg   <= next_word;
      pos    <= '0;
      long_q <= next_long;
    end else begin
      sreg   <= sreg >> 1;
      pos    <= pos + 1'b1;
    end
  end

  assign bit_q = sreg[0];
  assign sof_q = (pos == '0);

  p_ready_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_ready && raw_ready));
  p_ready_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ready || raw_ready) |=> sof_q);
  p_raw_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
    raw_ready |=> long_q);
  p_sof_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |=> !sof_q);
  p_size_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_q |-> $stable(long_q));
endmodule

// File: rtl/framer_delay.sv
module framer_delay #(
  parameter int unsigned W     = 3,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned TW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tap,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  logic [W-1:0] st [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else begin
      st[0] <= din;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign dout = st[tap];

  p_first_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (st[0] == $past(din)));
endmodule

// File: rtl/serial_framer.sv
module serial_framer
  import framer_pkg::*;
#(
  parameter int unsigned GEN_W       = 16,
  parameter logic [15:0] GEN_TAPS    = 16'hD008,
  parameter int unsigned BITS_PER_BC = 8,
  parameter int unsigned COARSE_W    = 2,
  parameter int unsigned FINE_W      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          src_sel,
  input  logic [BYTE_W-1:0]   const_val,
  input  logic [GEN_W-1:0]    seed_val,
  input  logic                seed_load,
  input  logic                lfsr_shift,
  input  logic [COARSE_W-1:0] coarse_dly,
  input  logic [FINE_W-1:0]   fine_dly,
  input  logic [BYTE_W-1:0]   en_data,
  input  logic                en_valid,
  output logic                en_ready,
  input  logic [RAW_W-1:0]    raw_data,
  input  logic                raw_valid,
  output logic                raw_ready,
  output logic                ser_o,
  output logic                sof_o,
  output logic                f10_o
);
  localparam int unsigned DEPTH = 1 + ((1 << COARSE_W) - 1) * BITS_PER_BC + ((1 << FINE_W) - 1);
  localparam int unsigned TW    = $clog2(DEPTH);
  localparam logic [TW-1:0] BPB = TW'(BITS_PER_BC);

  logic [GEN_W-1:0] gen_q;
  logic             bit_i, sof_i, long_i;
  logic [TW-1:0]    tap;
  logic [2:0]       dly_out;

  framer_lfsr #(.W(GEN_W), .TAPS(GEN_TAPS[GEN_W-1:0])) u_gen (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_val),
    .shift(lfsr_shift), .q(gen_q)
  );

  framer_frame #(.SHORT_W(BYTE_W), .LONG_W(RAW_W), .GEN_W(GEN_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .const_val(const_val),
    .gen_q(gen_q), .en_data(en_data), .en_valid(en_valid), .en_ready(en_ready),
    .raw_data(raw_data), .raw_valid(raw_valid), .raw_ready(raw_ready),
    .bit_q(bit_i), .sof_q(sof_i), .long_q(long_i)
  );

  assign tap = TW'(coarse_dly) * BPB + TW'(fine_dly);

  framer_delay #(.W(3), .DEPTH(DEPTH)) u_dly (
    .clk(clk), .rst_n(rst_n), .tap(tap),
    .din({long_i, sof_i, bit_i}), .dout(dly_out)
  );

  assign {f10_o, sof_o, ser_o} = dly_out;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> !(ser_o || sof_o || f10_o || en_ready || raw_ready));
endmodule

// File: tb/serial_framer_bench.sv
`timescale 1ns/1ps
module serial_framer_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  src_sel = 0;
  logic [7:0]  const_val = 0;
  logic [15:0] seed_val = 0;
  logic        seed_load = 0, lfsr_shift = 0;
  logic [1:0]  coarse_dly = 0;
  logic [2:0]  fine_dly = 0;
  logic [7:0]  en_data = 0;
  logic        en_valid = 0;
  logic        en_ready;
  logic [9:0]  raw_data = 0;
  logic        raw_valid = 0;
  logic        raw_ready;
  logic        ser_o, sof_o, f10_o;

  always #2 clk = ~clk;

  serial_framer u_serial_framer (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .const_val(const_val),
    .seed_val(seed_val), .seed_load(seed_load), .lfsr_shift(lfsr_shift),
    .coarse_dly(coarse_dly), .fine_dly(fine_dly),
    .en_data(en_data), .en_valid(en_valid), .en_ready(en_ready),
    .raw_data(raw_data), .raw_valid(raw_valid), .raw_ready(raw_ready),
    .ser_o(ser_o), .sof_o(sof_o), .f10_o(f10_o)
  );

  typedef struct { int due; logic [9:0] data; bit is10; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0, cyc = 0, dly = 1;
  bit done = 0;

  // model state
  bit m_last = 1; int m_pos = 0, m_len = 8; logic [15:0] m_gen = 0;
  // monitor state
  bit cap_on = 0; int cap_n = 0; exp_t cap;
  logic [9:0] cap_bits;

  function automatic logic [15:0] gen_step(logic [15:0] g);
    return {g[14:0], ~(g[15] ^ g[14] ^ g[12] ^ g[3])};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cyc %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      sb.delete(); m_last = 1; m_pos = 0; m_len = 8; m_gen = 0; cap_on = 0;
    end else begin
      // monitor: frame capture and compare
      if (cap_on) begin
        if (sof_o) check(0, "R6", "sof inside frame", 1, 0);
        if (f10_o != cap.is10) check(0, "R5", "f10 mid-frame", f10_o, cap.is10);
        cap_bits[cap_n] = ser_o;
        cap_n++;
        if (cap_n == (cap.is10 ? 10 : 8)) begin
          cap_on = 0;
          check(cap_bits == cap.data, "R6", "frame data", cap_bits, cap.data);
        end
      end else if (sof_o) begin
        if (sb.size() == 0) check(0, "R6", "unexpected frame", 1, 0);
        else begin
          cap = sb.pop_front();
          check(cap.due == cyc, "R8", "frame arrival cycle", cyc, cap.due);
          check(f10_o == cap.is10, "R5", "f10 at sof", f10_o, cap.is10);
          cap_bits = '0; cap_bits[0] = ser_o; cap_n = 1; cap_on = 1;
        end
      end
      // model: ready prediction and expected frames
      check(en_ready == (m_last && src_sel == 2'b00), "R2", "en_ready", en_ready, m_last && src_sel == 2'b00);
      check(raw_ready == (m_last && src_sel == 2'b11), "R5", "raw_ready", raw_ready, m_last && src_sel == 2'b11);
      if (m_last) begin
        exp_t e;
        e.due = cyc + 1 + dly;
        e.is10 = (src_sel == 2'b11);
        case (src_sel)
          2'b00: e.data = en_valid ? {2'b00, en_data} : 10'h0;
          2'b01: e.data = {2'b00, const_val};
          2'b10: e.data = {2'b00, m_gen[7:0]};
          default: e.data = raw_valid ? raw_data : 10'h0;
        endcase
        sb.push_back(e);
        m_len = e.is10 ? 10 : 8; m_pos = 0;
      end else m_pos++;
      m_last = (m_pos == m_len - 1);
      if (seed_load) m_gen = seed_val;
      else if (lfsr_shift) m_gen = gen_step(m_gen);
    end
  end

  task automatic tick(int n); repeat (n) @(posedge clk); #1; endtask

  task automatic send_en(logic [7:0] d);
    en_data = d; en_valid = 1;
    do @(negedge clk); while (!en_ready);
    @(posedge clk); #1 en_valid = 0;
  endtask

  task automatic send_raw(logic [9:0] d);
    raw_data = d; raw_valid = 1;
    do @(negedge clk); while (!raw_ready);
    @(posedge clk); #1 raw_valid = 0;
  endtask

  task automatic do_reset(logic [1:0] c, logic [2:0] f);
    tick(50);
    rst_n = 0; coarse_dly = c; fine_dly = f; dly = 1 + 8 * c + f;
    tick(3);
    @(negedge clk);
    check({ser_o, sof_o, f10_o, en_ready, raw_ready} == 5'b0, "R1", "outputs in reset",
          {ser_o, sof_o, f10_o, en_ready, raw_ready}, 0);
    @(posedge clk); #1 rst_n = 1;
  endtask

  task automatic run_suite();
    // R2 energy bytes with gaps
    src_sel = 2'b00;
    send_en(8'hA5); send_en(8'h3C); tick(17); send_en(8'hFF); send_en(8'h01);
    // R3 constant, then changed
    src_sel = 2'b01; const_val = 8'h5A; tick(20); const_val = 8'hC3; tick(20);
    // R4 / R9 generator
    src_sel = 2'b10; seed_val = 16'h1234;
    seed_load = 1; tick(1); seed_load = 0; tick(19);
    lfsr_shift = 1; tick(3); lfsr_shift = 0; tick(20);
    lfsr_shift = 1; tick(45); seed_load = 1; seed_val = 16'h00F1; tick(1);
    seed_load = 0; tick(30); lfsr_shift = 0; tick(12);
    // R5 raw 10-bit frames with gap
    src_sel = 2'b11;
    send_raw(10'h3A5); send_raw(10'h001); tick(13); send_raw(10'h200);
    // R7 mid-frame switching between sizes
    src_sel = 2'b00; tick(3); src_sel = 2'b11; tick(5); src_sel = 2'b01; tick(9);
    src_sel = 2'b11; tick(4); src_sel = 2'b00; en_data = 8'h96; en_valid = 1; tick(2);
    src_sel = 2'b10; en_valid = 0; tick(7); src_sel = 2'b01; tick(25);
  endtask

  initial begin
    do_reset(2'd0, 3'd0);  // R8 minimum delay
    run_suite();
    do_reset(2'd3, 3'd7);  // R8 maximum delay
    run_suite();
    do_reset(2'd1, 3'd3);  // R8 middle
    run_suite();
    tick(60);
    foreach (sb[i]) check(sb[i].due > cyc, "R6", "frame never seen", cyc, sb[i].due);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule